// File: doc/BRIEF.md
# Lookahead Head-Cache Refill Scheduler

This block keeps a small fast head cache for a set of FIFO queues whose bodies live in a slow, wide bulk memory. The bulk memory can only be read one whole block of `BLK` bytes at a time, so one refill can be started every `BLK` slots. A downstream scheduler asks for one byte per slot and names the queue it wants. Each request enters a lookahead delay line. It leaves the block a fixed number of slots later, and the byte it asked for is taken from that queue's head cache at that point.

Once every `BLK` slots the block looks at all requests waiting in the delay line. For each queue it counts them from the oldest to the newest and finds the first point at which that queue's demand exceeds the bytes it holds in cache. The refill goes to the queue that runs short soonest. A queue that holds little data but has nothing pending is left alone. The refill command names a queue. The bulk-memory side returns the block in the slot in which the command is shown, and the block is appended to that queue's cache. With a lookahead of `NQ*(BLK-1)+3` slots, every request finds its byte already cached when it leaves. This figure is the usual `NQ*(BLK-1)+1`, plus two slots for the command and data hand-off.

Top module: `head_cache_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `refill_valid`, `dep_valid` and `underrun` are 0.
- R2: A request accepted on a clock edge is presented on `dep_valid`/`dep_qid` exactly LAT = NQ*(BLK-1)+3 edges later (11 with defaults). A slot with no request yields `dep_valid` = 0 LAT edges later.
- R3: Bytes of each queue leave in the order of that queue's stream. In `fill_data`, byte lane j (bits 8j+7..8j) holds the j-th byte of the block, and lane 0 comes first.
- R4: Refill decisions are taken only in every BLK-th cycle, counting from the first cycle after reset, so two assertions of `refill_valid` are at least BLK cycles apart. `fill_valid` is only legal in a cycle where `refill_valid` is high, and its block is appended to queue `refill_qid`.
- R5: The refilled queue is the one whose cached byte count is first exceeded when pending requests are counted from oldest to newest. It is not chosen by lowest occupancy or by lowest index.
- R6: A queue whose pending requests do not exceed its cached bytes is never refilled. With no such queue in a decision slot, no command is issued.
- R7: For any request stream of at most one request per slot, no departing request finds its queue's cache empty, and `underrun` stays 0. `underrun` is registered with `dep_valid` and would flag such an empty-cache departure.
- R8: A queue's cache never holds more than LAT+BLK bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A byte request is offered this slot |
| req_qid | input | QW | Queue the byte is requested from |
| fill_valid | input | 1 | Bulk block returned this slot |
| fill_data | input | BLK*8 | Returned block, lane 0 first |
| refill_valid | output | 1 | Refill command for one queue |
| refill_qid | output | QW | Queue to be refilled |
| dep_valid | output | 1 | A request leaves the pipeline |
| dep_qid | output | QW | Queue of the departing request |
| dep_data | output | 8 | Byte delivered for the departing request |
| underrun | output | 1 | Departing request found an empty cache |

## Verification
The two internal states that can go wrong are the cached byte counts and the delay-line contents. A cached count that drifts, or a bad refill choice, shows on `dep_data` as a byte out of stream order. At worst it raises `underrun`, no later than one lookahead of LAT slots after the faulty refill. A fault in the delay line shows as a departure that is off by slots or carries the wrong queue, within LAT edges of the request. A wrong pick rule can stay hidden under steady traffic. It therefore needs directed sequences that separate "oldest shortfall first" from "emptiest first" and from "lowest index first", and it shows in the order of the commands on `refill_qid`.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

  typedef logic [7:0] byte_t;

  // Slots a request spends in the lookahead line: the bound NQ*(BLK-1)+1
  // plus one slot for the registered command and one for the data return.
  function automatic int lookahead_len(input int nq, input int blk);
    return nq * (blk - 1) + 3;
  endfunction

  // Circular index advance without a divider.
  function automatic int wrap_add(input int base, input int step, input int depth);
    int r;
    r = base + step;
    if (r >= depth) r = r - depth;
    return r;
  endfunction

endpackage

// File: rtl/hcs_lookahead_pipe.sv
module hcs_lookahead_pipe #(
  parameter int LAT = 11,
  parameter int QW  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [QW-1:0]           in_qid,
  output logic [LAT-1:0]          stage_valid,
  output logic [LAT-1:0][QW-1:0]  stage_qid,
  output logic                    out_valid,
  output logic [QW-1:0]           out_qid
);

  // Stage 0 holds the newest request, stage LAT-1 the one leaving now.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_valid <= '0;
      stage_qid   <= '0;
    end else begin
      stage_valid <= {stage_valid[LAT-2:0], in_valid};
      stage_qid   <= {stage_qid[LAT-2:0], in_qid};
    end
  end

  assign out_valid = stage_valid[LAT-1];
  assign out_qid   = stage_qid[LAT-1];

endmodule

// File: rtl/hcs_queue_cache.sv
module hcs_queue_cache #(
  parameter int BLK   = 3,
  parameter int DEPTH = 14,
  parameter int CW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [BLK*8-1:0]   push_data,
  input  logic               pop,
  output hcs_pkg::byte_t     head,
  output logic [CW-1:0]      count
);

  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  hcs_pkg::byte_t  mem [DEPTH];
  logic [PTRW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0]   count_nxt;
  logic            do_pop;

  function automatic logic [PTRW-1:0] slot_of(input logic [PTRW-1:0] base, input int step);
    return PTRW'(hcs_pkg::wrap_add(int'(base), step, DEPTH));
  endfunction

  assign do_pop = pop && (count != '0);
  assign head   = mem[rd_ptr];

  always_comb begin
    count_nxt = count;
    if (push)   count_nxt = count_nxt + CW'(BLK);
    if (do_pop) count_nxt = count_nxt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (push) begin
      for (int j = 0; j < BLK; j++) begin
        mem[slot_of(wr_ptr, j)] <= push_data[j*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= slot_of(wr_ptr, BLK);
      if (do_pop) rd_ptr <= slot_of(rd_ptr, 1);
      count <= count_nxt;
    end
  end

  // R8: a refill block must always fit behind the bytes already cached.
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(count) + BLK <= DEPTH));

endmodule

// File: rtl/hcs_refill_picker.sv
module hcs_refill_picker #(
  parameter int NQ    = 4,
  parameter int LAT   = 11,
  parameter int QW    = 2,
  parameter int CW    = 4,
  parameter int DISTW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LAT-1:0]          stage_valid,
  input  logic [LAT-1:0][QW-1:0]  stage_qid,
  input  logic [NQ-1:0][CW-1:0]   counts,
  output logic                    pick_valid,
  output logic [QW-1:0]           pick_qid,
  output logic [DISTW-1:0]        pick_dist
);

  int                    short_at [NQ];
  logic [NQ-1:0][LAT-1:0] wants;
  logic [NQ-1:0]          demand_seen;

  // Distance (0 = leaving now) of the first pending request of queue q
  // that its cached bytes can no longer cover; -1 when all are covered.
  function automatic int first_short(input int q,
                                     input logic [LAT-1:0] sv,
                                     input logic [LAT-1:0][QW-1:0] sq,
                                     input int have);
    int need;
    int hit;
    need = 0;
    hit  = -1;
    for (int i = 0; i < LAT; i++) begin
      if (sv[LAT-1-i] && (int'(sq[LAT-1-i]) == q)) need = need + 1;
      if ((hit < 0) && (need > have)) hit = i;
    end
    return hit;
  endfunction

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      short_at[q] = first_short(q, stage_valid, stage_qid, int'(counts[q]));
    end
  end

  // Earliest shortfall wins; strict compare keeps the lowest index on a tie.
  always_comb begin
    int best;
    best       = LAT;
    pick_valid = 1'b0;
    pick_qid   = '0;
    for (int q = 0; q < NQ; q++) begin
      if ((short_at[q] >= 0) && (short_at[q] < best)) begin
        best       = short_at[q];
        pick_valid = 1'b1;
        pick_qid   = QW'(q);
      end
    end
    pick_dist = DISTW'(best);
  end

  // Independent per-queue demand map, used only to guard the pick.
  for (genvar q = 0; q < NQ; q++) begin : g_want
    for (genvar s = 0; s < LAT; s++) begin : g_stage
      assign wants[q][s] = stage_valid[s] && (stage_qid[s] == QW'(q));
    end
    assign demand_seen[q] = |wants[q];
  end

  // R6: a queue with nothing pending is never the candidate.
  assert_pick_has_demand_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> demand_seen[pick_qid]);

endmodule

// File: rtl/head_cache_sched.sv
module head_cache_sched #(
  parameter int NQ  = 4,
  parameter int BLK = 3,
  parameter int QW  = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [QW-1:0]      req_qid,
  input  logic               fill_valid,
  input  logic [BLK*8-1:0]   fill_data,
  output logic               refill_valid,
  output logic [QW-1:0]      refill_qid,
  output logic               dep_valid,
  output logic [QW-1:0]      dep_qid,
  output logic [7:0]         dep_data,
  output logic               underrun
);

  localparam int LAT   = hcs_pkg::lookahead_len(NQ, BLK);
  localparam int DEPTH = LAT + BLK;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int PW    = (BLK > 1) ? $clog2(BLK) : 1;
  localparam int DISTW = $clog2(LAT + 1);

  logic [LAT-1:0]          stage_valid;
  logic [LAT-1:0][QW-1:0]  stage_qid;
  logic                    out_valid;
  logic [QW-1:0]           out_qid;
  logic [NQ-1:0][CW-1:0]   counts;
  logic [NQ-1:0][7:0]      heads;
  logic                    pick_valid;
  logic [QW-1:0]           pick_qid;
  logic [DISTW-1:0]        pick_dist;
  logic [PW-1:0]           phase;

  // Named internal events.
  logic decide_slot, refill_fire, pop_empty;
  assign decide_slot = (phase == '0);
  assign refill_fire = decide_slot && pick_valid;
  assign pop_empty   = out_valid && (counts[out_qid] == '0);

  hcs_lookahead_pipe #(.LAT(LAT), .QW(QW)) i_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (req_valid),
    .in_qid      (req_qid),
    .stage_valid (stage_valid),
    .stage_qid   (stage_qid),
    .out_valid   (out_valid),
    .out_qid     (out_qid)
  );

  for (genvar g = 0; g < NQ; g++) begin : g_cache
    hcs_queue_cache #(.BLK(BLK), .DEPTH(DEPTH), .CW(CW)) i_cache (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (fill_valid && (refill_qid == QW'(g))),
      .push_data (fill_data),
      .pop       (out_valid && (out_qid == QW'(g))),
      .head      (heads[g]),
      .count     (counts[g])
    );
  end

  hcs_refill_picker #(.NQ(NQ), .LAT(LAT), .QW(QW), .CW(CW), .DISTW(DISTW)) i_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .stage_valid (stage_valid),
    .stage_qid   (stage_qid),
    .counts      (counts),
    .pick_valid  (pick_valid),
    .pick_qid    (pick_qid),
    .pick_dist   (pick_dist)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= '0;
      refill_valid <= 1'b0;
      refill_qid   <= '0;
      dep_valid    <= 1'b0;
      dep_qid      <= '0;
      dep_data     <= '0;
      underrun     <= 1'b0;
    end else begin
      phase        <= (phase == PW'(BLK - 1)) ? '0 : phase + PW'(1);
      refill_valid <= refill_fire;
      if (refill_fire) refill_qid <= pick_qid;
      dep_valid    <= out_valid;
      dep_qid      <= out_qid;
      dep_data     <= heads[out_qid];
      underrun     <= pop_empty;
    end
  end

  // R4: commands are spaced by the block period.
  assert_cmd_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |=> !refill_valid);

  // R4: a returned block must answer a command shown in the same slot.
  assert_fill_with_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> refill_valid);

  // R7: a chosen queue's first shortfall is still far enough away for the block to land.
  assert_refill_in_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refill_fire |-> (pick_dist >= DISTW'(2)));

  // R7: the pipeline never releases a request against an empty cache.
  assert_no_underrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (counts[out_qid] != '0));

endmodule

// File: tb/test_head_cache_sched.sv
module test_head_cache_sched;

  localparam int NQ  = 4;
  localparam int BLK = 3;
  localparam int QW  = 2;
  localparam int LAT = NQ * (BLK - 1) + 3;
  localparam int HL  = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [QW-1:0]    req_qid = '0;
  logic             fill_valid = 1'b0;
  logic [BLK*8-1:0] fill_data = '0;
  logic             refill_valid;
  logic [QW-1:0]    refill_qid;
  logic             dep_valid;
  logic [QW-1:0]    dep_qid;
  logic [7:0]       dep_data;
  logic             underrun;

  head_cache_sched #(.NQ(NQ), .BLK(BLK), .QW(QW)) i_head_cache_sched (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_qid (req_qid),
    .fill_valid (fill_valid), .fill_data (fill_data),
    .refill_valid (refill_valid), .refill_qid (refill_qid),
    .dep_valid (dep_valid), .dep_qid (dep_qid), .dep_data (dep_data),
    .underrun (underrun)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  logic [QW:0] hist [HL];
  int blkcnt [NQ];
  int cons   [NQ];
  int ncmd = 0;
  int cmd_log [256];
  int last_cmd = -100;

  initial begin
    for (int i = 0; i < HL; i++) hist[i] = '0;
    for (int q = 0; q < NQ; q++) begin blkcnt[q] = 0; cons[q] = 0; end
  end

  function automatic logic [7:0] stream_byte(input int q, input int n);
    return {q[1:0], n[5:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Request history, indexed by the edge number that accepted the request.
  always @(posedge clk) begin
    hist[(cyc + 1) % HL] <= rst_n ? {req_valid, req_qid} : '0;
    cyc <= cyc + 1;
  end

  // Bulk-memory model, cadence check, departure checks.
  always @(negedge clk) begin
    if (refill_valid) begin
      check((cyc - last_cmd) >= BLK, "R4 command spacing", cyc - last_cmd, BLK);
      last_cmd = cyc;
      cmd_log[ncmd % 256] = int'(refill_qid);
      ncmd++;
      fill_valid = 1'b1;
      for (int j = 0; j < BLK; j++)
        fill_data[j*8 +: 8] = stream_byte(int'(refill_qid), blkcnt[refill_qid] * BLK + j);
      blkcnt[refill_qid]++;
    end else begin
      fill_valid = 1'b0;
    end
    if (rst_n && cyc >= LAT && !done) begin
      logic [QW:0] e;
      e = hist[(cyc - LAT) % HL];
      check(dep_valid == e[QW], "R2 departure slot", int'(dep_valid), int'(e[QW]));
      if (dep_valid && e[QW]) begin
        check(dep_qid == e[QW-1:0], "R2 departure queue", int'(dep_qid), int'(e[QW-1:0]));
        check(dep_data == stream_byte(int'(dep_qid), cons[dep_qid]), "R3 byte order",
              int'(dep_data), int'(stream_byte(int'(dep_qid), cons[dep_qid])));
        check(underrun == 1'b0, "R7 underrun", int'(underrun), 0);
        cons[dep_qid]++;
      end
    end
    if (cyc > 60000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic send(input int q);
    @(negedge clk);
    req_valid = 1'b1;
    req_qid   = QW'(q);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic drain;
    idle(LAT + 2 * BLK + 4);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    check(!refill_valid && !dep_valid && !underrun, "R1 outputs in reset",
          int'({refill_valid, dep_valid, underrun}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!refill_valid && !dep_valid && !underrun, "R1 first cycle after reset",
          int'({refill_valid, dep_valid, underrun}), 0);
  endtask

  task automatic t_idle;
    int start;
    start = ncmd;
    idle(30);
    check(ncmd == start, "R6 no demand no refill", ncmd - start, 0);
  endtask

  // Older shortfall on q3 must precede q1, despite q1's lower index.
  task automatic t_choice;
    int start;
    start = ncmd;
    send(3);
    send(1);
    drain();
    check(ncmd - start == 2, "R5 refill count", ncmd - start, 2);
    check(cmd_log[start % 256] == 3, "R5 oldest shortfall first", cmd_log[start % 256], 3);
    check(cmd_log[(start + 1) % 256] == 1, "R5 second pick", cmd_log[(start + 1) % 256], 1);
  endtask

  // q3 holds 2 bytes: one request is covered, while empty q0/q2 stay untouched.
  task automatic t_covered;
    int start;
    start = ncmd;
    send(3);
    drain();
    check(ncmd == start, "R6 covered request", ncmd - start, 0);
    start = ncmd;
    send(3);
    send(3);
    drain();
    check(ncmd - start == 1, "R6 single shortfall refill", ncmd - start, 1);
    check(cmd_log[start % 256] == 3, "R5 shortfall queue", cmd_log[start % 256], 3);
  endtask

  task automatic t_flood(input int q, input int n);
    for (int i = 0; i < n; i++) send(q);
    drain();
  endtask

  task automatic t_round_robin(input int n);
    for (int i = 0; i < n; i++) send(i % NQ);
    drain();
  endtask

  task automatic t_lfsr(input int n);
    logic [7:0] r;
    r = 8'h5a;
    for (int i = 0; i < n; i++) begin
      r = {r[6:0], r[7] ^ r[5] ^ r[4] ^ r[3]};
      if (r[7:5] == 3'b000) idle(1);
      else send(int'(r[1:0]));
    end
    drain();
  endtask

  // Bursts of different lengths per queue, back to back.
  task automatic t_bursts;
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < k + 1; i++) send((k * 3) % NQ);
      for (int i = 0; i < 2 * BLK; i++) send(NQ - 1 - (k % NQ));
    end
    drain();
  endtask

  initial begin
    t_reset();
    t_idle();
    t_choice();
    t_covered();
    t_flood(0, 150);
    t_round_robin(200);
    t_bursts();
    t_lfsr(1500);
    t_flood(2, 40);
    check(underrun == 1'b0, "R7 end of run", int'(underrun), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule